// File: doc/BRIEF.md
# Segmented Bus Cycle Controller

This block is the external-bus side of a small processor core. An internal requester hands it one access at a time. Each access is a memory or I/O read or write. The block runs that access as a multi-phase cycle on a 20-bit address bus and a 16-bit data bus, then returns a completion pulse with any read data.

For memory accesses, the physical address is built from a 16-bit segment and a 16-bit offset: the segment is shifted left by four bits and the offset is added. For I/O accesses, the offset is used directly as the port number.

Each cycle follows a fixed sequence of phases:
- an address phase with a one-clock latch strobe;
- a strobe phase in which the active-low read or write strobe falls;
- a sampling phase that waits for the ready input;
- any number of wait phases while ready stays low;
- a closing phase that releases the strobe and reports completion.

The data bus is split into an output, an output enable and an input, so a pad ring can build the bidirectional pins.

The request side is valid/ready. `req_ready` is high only while the controller is idle. A request is taken on the rising edge where both `req_valid` and `req_ready` are high, and its fields are captured on that edge. While a cycle is in flight, `req_ready` stays low. During that time, request fields may change and `req_valid` may be held high, and neither has any effect. The response side has no back-pressure: `rsp_valid` is a one-clock pulse that the requester must take when it appears.

Top module: `bus_cycle_unit`

## Requirements
- R1: For a memory access (`req_io`=0), `bus_addr` equals (`req_seg`·16 + `req_off`) modulo 2^20 from the first cycle after acceptance until the response cycle, inclusive.
- R2: For an I/O access (`req_io`=1), `bus_addr[19:16]` is 0 and `bus_addr[15:0]` equals `req_off` over the same window; `bus_mem_io` is 0 for I/O and 1 for memory over that window.
- R3: `bus_ale` is 1 for exactly the first cycle after acceptance, with both strobes high in that cycle.
- R4: For a read, `bus_rd_n` is 0 from the second cycle after acceptance up to and including the cycle in which `bus_ready` is sampled 1; `bus_wr_n` stays 1 throughout.
- R5: For a write, `bus_wr_n` is 0 and `bus_doe` is 1 over the same window as R4, with `bus_dout` equal to `req_wdata`; `bus_rd_n` stays 1.
- R6: `bus_ready` is sampled from the third cycle after acceptance onward. Each sampled 0 adds one more strobe cycle.
- R7: On a read, the value of `bus_din` at the edge where `bus_ready` is first sampled 1 appears on `rsp_rdata` in the response cycle.
- R8: `rsp_valid` is 1 for exactly one cycle: the cycle after the last strobe cycle, that is, 4 + n cycles after acceptance for n wait states. All strobes are high in that cycle.
- R9: `req_ready` is 0 from acceptance through the response cycle. A request held or changed during that time does not alter the running cycle's address.
- R10: `bus_doe` is 0 during reads, during the address and response phases, and while idle.
- R11: After reset, `req_ready`=1, `bus_rd_n`=1, `bus_wr_n`=1, `bus_ale`=0, `bus_doe`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken on this edge if valid |
| req_io | input | 1 | 1 = I/O access, 0 = memory access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_seg | input | 16 | Segment value (memory only) |
| req_off | input | 16 | Offset, or port number for I/O |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| bus_addr | output | 20 | External address |
| bus_ale | output | 1 | Address latch strobe |
| bus_mem_io | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 16 | Outgoing data bus value |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | 16 | Incoming data bus value |
| bus_ready | input | 1 | Low inserts wait states |

## Verification
The completion pulse and a fresh request can land in the same cycle. The bench provokes this by holding `req_valid` high through a whole cycle while changing the offset. It then judges that the held request does not move the running address, that `req_ready` stays low alongside `rsp_valid`, and that no new latch strobe appears before the idle cycle. A second overlap comes from the ready input returning high in the very sampling cycle, with zero waits. It is judged by checking that the strobe ends and the read data is captured on that same edge.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bcu_state_t;
endpackage

// File: rtl/bcu_addr_gen.sv
module bcu_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic              is_io,
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);
  localparam int PAD_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] mem_addr;

  generate
    if (SEG_W + SHIFT >= ADDR_W) begin : g_seg_trim
      logic [SEG_W+SHIFT-1:0] seg_wide;
      assign seg_wide = {seg, {SHIFT{1'b0}}};
      assign seg_ext  = seg_wide[ADDR_W-1:0];
    end else begin : g_seg_pad
      assign seg_ext = {{(ADDR_W-SEG_W-SHIFT){1'b0}}, seg, {SHIFT{1'b0}}};
    end
    if (PAD_W > 0) begin : g_off_pad
      assign off_ext = {{PAD_W{1'b0}}, off};
    end else begin : g_off_trim
      assign off_ext = off[ADDR_W-1:0];
    end
  endgenerate

  assign mem_addr = seg_ext + off_ext;
  assign phys     = is_io ? off_ext : mem_addr;
endmodule

// File: rtl/bcu_seq.sv
module bcu_seq
  import bcu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bus_ready,
  output logic idle,
  output logic ale,
  output logic strobe_on,
  output logic capture,
  output logic done
);
  bcu_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start) state_nx = ST_T1;
      ST_T1:   state_nx = ST_T2;
      ST_T2:   state_nx = ST_T3;
      ST_T3:   state_nx = bus_ready ? ST_T4 : ST_TW;
      ST_TW:   state_nx = bus_ready ? ST_T4 : ST_TW;
      ST_T4:   state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign idle      = (state == ST_IDLE);
  assign ale       = (state == ST_T1);
  assign strobe_on = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
  assign capture   = ((state == ST_T3) || (state == ST_TW)) && bus_ready;
  assign done      = (state == ST_T4);

  // R3: the latch strobe is one clock long and leads into the strobe phase
  assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && strobe_on));
  // R6: a low ready in a sampling phase keeps the strobe active
  assert_wait_extends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && !ale && !bus_ready && !(state == ST_T2)) |=> (strobe_on && !done));
  // R8: completion is a single pulse followed by idle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && idle));
  // R9: a start is only honoured from idle
  assert_start_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> (ale && !idle));
endmodule

// File: rtl/bcu_data_path.sv
module bcu_data_path #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] phys_in,
  input  logic              is_io,
  input  logic              is_write,
  input  logic [DATA_W-1:0] wdata,
  input  logic              strobe_on,
  input  logic              capture,
  input  logic              idle,
  input  logic              ale,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_io,
  output logic              rd_n,
  output logic              wr_n,
  output logic              doe,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rdata
);
  logic write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      mem_io  <= 1'b1;
      write_q <= 1'b0;
      dout    <= '0;
    end else if (load) begin
      addr    <= phys_in;
      mem_io  <= ~is_io;
      write_q <= is_write;
      dout    <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata <= '0;
    else if (capture && !write_q) rdata <= bus_din;
  end

  assign rd_n = ~(strobe_on && !write_q);
  assign wr_n = ~(strobe_on && write_q);
  assign doe  = strobe_on && write_q;

  // R4: the two strobes are never active together
  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R10: the data bus is driven only alongside an active write strobe
  assert_doe_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> !wr_n);
  // R1: the address holds steady across a running cycle
  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !ale) |-> $stable(addr));
endmodule

// File: rtl/bus_cycle_unit.sv
module bus_cycle_unit #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_io,
  input  logic              req_write,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ale,
  output logic              bus_mem_io,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ready
);
  logic              idle, strobe_on, capture, accept;
  logic [ADDR_W-1:0] phys;

  assign accept    = req_valid && idle;
  assign req_ready = idle;

  bcu_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_addr (
    .is_io (req_io),
    .seg   (req_seg),
    .off   (req_off),
    .phys  (phys)
  );

  bcu_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .bus_ready (bus_ready),
    .idle      (idle),
    .ale       (bus_ale),
    .strobe_on (strobe_on),
    .capture   (capture),
    .done      (rsp_valid)
  );

  bcu_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .phys_in   (phys),
    .is_io     (req_io),
    .is_write  (req_write),
    .wdata     (req_wdata),
    .strobe_on (strobe_on),
    .capture   (capture),
    .idle      (idle),
    .ale       (bus_ale),
    .bus_din   (bus_din),
    .addr      (bus_addr),
    .mem_io    (bus_mem_io),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .doe       (bus_doe),
    .dout      (bus_dout),
    .rdata     (rsp_rdata)
  );

  // R8: completion never overlaps an active strobe
  assert_done_strobes_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (bus_rd_n && bus_wr_n && !bus_doe));
  // R9: the requester sees no readiness while a cycle runs
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n || bus_ale || rsp_valid) |-> !req_ready);
endmodule

// File: tb/test_bus_cycle_unit.sv
module test_bus_cycle_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0;
  logic [15:0] req_seg = '0, req_off = '0, req_wdata = '0, bus_din = '0;
  logic        bus_ready = 1'b1;
  logic        req_ready, rsp_valid, bus_ale, bus_mem_io, bus_rd_n, bus_wr_n, bus_doe;
  logic [15:0] rsp_rdata, bus_dout;
  logic [19:0] bus_addr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bus_cycle_unit i_bus_cycle_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_io(req_io), .req_write(req_write), .req_seg(req_seg), .req_off(req_off),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_mem_io(bus_mem_io),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_ready(bus_ready)
  );

  function automatic logic [19:0] exp_addr(input logic io, input logic [15:0] seg,
                                           input logic [15:0] off);
    logic [19:0] a;
    if (io) a = {4'h0, off};
    else    a = {seg, 4'h0} + {4'h0, off};
    return a;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One complete bus cycle; hold=1 keeps req_valid high and disturbs the offset.
  task automatic run_cycle(input logic io, input logic wr, input logic [15:0] seg,
                           input logic [15:0] off, input logic [15:0] wd,
                           input int nwait, input logic [15:0] rd, input bit hold);
    logic [19:0] ea;
    logic        rstrobe, wstrobe;
    ea = exp_addr(io, seg, off);
    req_valid = 1'b1; req_io = io; req_write = wr;
    req_seg = seg; req_off = off; req_wdata = wd;
    bus_ready = 1'b1;
    chk(req_ready == 1'b1, "R9 idle ready", {31'd0, req_ready}, 1);
    step();
    // address phase
    if (!hold) req_valid = 1'b0;
    else req_off = off ^ 16'h5A5A;
    chk(bus_ale == 1'b1, "R3 ale in T1", {31'd0, bus_ale}, 1);
    chk(bus_rd_n && bus_wr_n, "R3 strobes high in T1", {30'd0, bus_rd_n, bus_wr_n}, 3);
    chk(bus_addr == ea, io ? "R2 io address" : "R1 mem address", {12'd0, bus_addr}, {12'd0, ea});
    chk(bus_mem_io == ~io, "R2 mem/io select", {31'd0, bus_mem_io}, {31'd0, ~io});
    chk(req_ready == 1'b0, "R9 busy", {31'd0, req_ready}, 0);
    chk(bus_doe == 1'b0, "R10 doe off in T1", {31'd0, bus_doe}, 0);
    rstrobe = !wr; wstrobe = wr;
    step();
    // strobe, sampling and wait phases
    for (int k = 0; k <= nwait + 1; k++) begin
      bit last;
      last = (k == nwait + 1);
      if (k >= 1) begin
        bus_ready = last ? 1'b1 : 1'b0;
        bus_din   = last ? rd : ~rd;
      end
      chk(bus_rd_n == !rstrobe, wr ? "R5 rd high on write" : "R4 rd low",
          {31'd0, bus_rd_n}, {31'd0, !rstrobe});
      chk(bus_wr_n == !wstrobe, wr ? "R5 wr low" : "R4 wr high on read",
          {31'd0, bus_wr_n}, {31'd0, !wstrobe});
      chk(bus_doe == wr, wr ? "R5 doe on" : "R10 doe off on read",
          {31'd0, bus_doe}, {31'd0, wr});
      if (wr) chk(bus_dout == wd, "R5 dout", {16'd0, bus_dout}, {16'd0, wd});
      chk(bus_addr == ea, "R9 address held", {12'd0, bus_addr}, {12'd0, ea});
      chk(bus_ale == 1'b0 && rsp_valid == 1'b0, "R6 no done while waiting",
          {30'd0, bus_ale, rsp_valid}, 0);
      step();
    end
    // response phase
    chk(rsp_valid == 1'b1, "R8 done pulse", {31'd0, rsp_valid}, 1);
    chk(bus_rd_n && bus_wr_n && !bus_doe, "R8 strobes released",
        {29'd0, bus_rd_n, bus_wr_n, bus_doe}, 6);
    chk(req_ready == 1'b0, "R9 not ready with done", {31'd0, req_ready}, 0);
    chk(bus_ale == 1'b0, "R3 no ale in T4", {31'd0, bus_ale}, 0);
    if (!wr) chk(rsp_rdata == rd, "R7 read data", {16'd0, rsp_rdata}, {16'd0, rd});
    req_valid = 1'b0;
    bus_ready = 1'b1;
    step();
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R8 single pulse",
        {30'd0, rsp_valid, req_ready}, 1);
    chk(bus_doe == 1'b0, "R10 doe off idle", {31'd0, bus_doe}, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && bus_rd_n && bus_wr_n && !bus_ale && !bus_doe && !rsp_valid,
        "R11 reset state",
        {26'd0, req_ready, bus_rd_n, bus_wr_n, bus_ale, bus_doe, rsp_valid}, 32'h38);
    rst_n = 1'b1;
    step();
    chk(req_ready == 1'b1 && bus_rd_n && bus_wr_n, "R11 after release",
        {29'd0, req_ready, bus_rd_n, bus_wr_n}, 7);
    // directed corners
    run_cycle(1'b0, 1'b0, 16'h1000, 16'h0010, 16'h0, 0, 16'hBEEF, 1'b0);
    run_cycle(1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0, 0, 16'h1234, 1'b0);
    run_cycle(1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0, 3, 16'h00A5, 1'b0);
    run_cycle(1'b0, 1'b1, 16'h2000, 16'h0100, 16'hCAFE, 5, 16'h0, 1'b0);
    run_cycle(1'b1, 1'b1, 16'h0000, 16'h0060, 16'h0042, 0, 16'h0, 1'b0);
    run_cycle(1'b0, 1'b0, 16'h0ABC, 16'h4321, 16'h0, 2, 16'h7777, 1'b1);
    run_cycle(1'b0, 1'b1, 16'h0ABC, 16'h4321, 16'h5555, 0, 16'h0, 1'b1);
    // random traffic
    for (int n = 0; n < 40; n++) begin
      run_cycle(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                16'($urandom), int'($urandom % 5), 16'($urandom), 1'($urandom % 4 == 0));
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule